// File: doc/BRIEF.md
# Integer ALU Execute Stage

A purely combinational 64-bit integer execute stage for a RISC-style core. It accepts an operation code, two operands, a carry input, a 32-bit-mode flag and a byte-length field. It performs one of three operations: add with carry, sign extension from a narrow width, or a byte-equality search. It returns a result together with carry, overflow and condition-field outputs.

Beside every destination the stage drives a write-valid flag. The flags for the result, condition field 0, the overflow pair and the carry pair are each raised only when the selected operation really writes that destination. A single adder provides both the 64-bit and the 32-bit carry and overflow flags. The stage holds no state: every output follows the present inputs.

Top module: `alu_exec_stage`

## Requirements
- R1: For add (op code 1), {ca_o, result_o} equals the 65-bit sum a_i + b_i + carry_i.
- R2: For add, ca32_o equals bit 32 of (a_i[31:0] + b_i[31:0] + carry_i).
- R3: For add, ov_o = (ca_o ^ result_o[63]) & ~(a_i[63] ^ b_i[63]), and ov32_o = (ca32_o ^ result_o[31]) & ~(a_i[31] ^ b_i[31]).
- R4: For sign extension (op code 2) with len_i equal to 1, 2 or 4, result_o[8N-1:0] copies a_i and all higher bits repeat a_i[8N-1]. For any other len_i, result_o equals a_i unchanged.
- R5: For byte compare (op code 3), result_o bit i (i = 0..7) is 1 when a_i[7:0] equals byte i of b_i, and bits 63:8 are 0. cr0_o bit 2 is the OR of those eight matches, and the other cr0_o bits are 0.
- R6: When mode32_i is 1, the upper 32 bits of both operands are taken as zero for every operation.
- R7: result_ok_o is 1 for op codes 1, 2 and 3, and 0 for every other op code.
- R8: ov_ok_o and ca_ok_o are 1 only for add. cr0_ok_o is 1 only for byte compare.
- R9: For an unrecognised op code, result_o, cr0_o, ov_o, ov32_o, ca_o and ca32_o are all 0.
- R10: ov_o, ov32_o, ca_o and ca32_o are 0 for every operation other than add, and cr0_o is 0 for every operation other than byte compare.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 3 | Operation code: 1 add, 2 sign extend, 3 byte compare, others none |
| a_i | input | 64 | Operand A |
| b_i | input | 64 | Operand B |
| carry_i | input | 1 | Carry input for add |
| mode32_i | input | 1 | 32-bit mode: upper operand halves read as zero |
| len_i | input | 4 | Source width in bytes for sign extension |
| result_o | output | 64 | Main result |
| result_ok_o | output | 1 | Result write-valid |
| cr0_o | output | 4 | Condition field 0 (bit 2 = byte match) |
| cr0_ok_o | output | 1 | Condition field 0 write-valid |
| ov_o | output | 1 | 64-bit overflow |
| ov32_o | output | 1 | 32-bit overflow |
| ov_ok_o | output | 1 | Overflow pair write-valid |
| ca_o | output | 1 | 64-bit carry out |
| ca32_o | output | 1 | 32-bit carry out |
| ca_ok_o | output | 1 | Carry pair write-valid |

## Verification
The bench builds the stage with its default width of 64 bits, so there are eight compared bytes and a 32-bit half. With this width, carries across both bit 32 and bit 64 can be reached from directed all-ones operands, and every sign-extension length fits below the top byte. Random operands are mixed with operands planted with matching bytes, and with codes outside the three operations, so that every write-valid flag is seen both high and low.

// File: rtl/alu_pkg.sv
package alu_pkg;
    typedef enum logic [2:0] {
        OP_NONE = 3'd0,
        OP_ADD  = 3'd1,
        OP_SEXT = 3'd2,
        OP_BCMP = 3'd3
    } alu_op_e;
endpackage

// File: rtl/alu_adder.sv
module alu_adder #(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  logic            cin,
    output logic [XLEN-1:0] sum,
    output logic            cout,
    output logic            cout_half,
    output logic            ovf,
    output logic            ovf_half
);
    localparam int HALF = XLEN / 2;

    logic [XLEN:0] wide;

    always_comb begin
        wide      = {1'b0, a} + {1'b0, b} + {{XLEN{1'b0}}, cin};
        sum       = wide[XLEN-1:0];
        cout      = wide[XLEN];
        // carry into bit HALF recovered from the sum bit and the operand bits
        cout_half = wide[HALF] ^ a[HALF] ^ b[HALF];
        ovf       = (cout ^ sum[XLEN-1]) & ~(a[XLEN-1] ^ b[XLEN-1]);
        ovf_half  = (cout_half ^ sum[HALF-1]) & ~(a[HALF-1] ^ b[HALF-1]);
    end

    // R3: a signed overflow is only possible when both operands share a sign
    always_comb begin
        a_r3_ovf_same_sign: assert (!ovf || (a[XLEN-1] == b[XLEN-1]))
            else $error("overflow raised with differing operand signs");
    end
endmodule

// File: rtl/alu_sext.sv
module alu_sext #(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] a,
    input  logic [3:0]      nbytes,
    output logic [XLEN-1:0] y
);
    localparam int NWID = 3;

    logic [XLEN-1:0] ext [NWID];

    for (genvar k = 0; k < NWID; k++) begin : g_width
        localparam int NB = 1 << k;
        assign ext[k] = {{(XLEN - 8*NB){a[8*NB-1]}}, a[8*NB-1:0]};
    end

    always_comb begin
        unique case (nbytes)
            4'd1:    y = ext[0];
            4'd2:    y = ext[1];
            4'd4:    y = ext[2];
            default: y = a;
        endcase
    end

    // R4: for a one-byte source, every bit above bit 7 repeats the sign bit
    always_comb begin
        if (nbytes == 4'd1) begin
            a_r4_byte_sign_fill: assert (y[XLEN-1:8] == {(XLEN-8){a[7]}})
                else $error("byte sign fill broken");
        end
    end
endmodule

// File: rtl/alu_bytecmp.sv
module alu_bytecmp #(
    parameter int XLEN = 64
) (
    input  logic [7:0]      key,
    input  logic [XLEN-1:0] b,
    output logic [XLEN-1:0] mask,
    output logic            any_hit
);
    localparam int NBYTE = XLEN / 8;

    logic [NBYTE-1:0] hit;

    for (genvar i = 0; i < NBYTE; i++) begin : g_byte
        assign hit[i] = (b[8*i +: 8] == key);
    end

    assign mask    = {{(XLEN-NBYTE){1'b0}}, hit};
    assign any_hit = |hit;

    // R5: the summary flag agrees with the per-byte mask
    always_comb begin
        a_r5_any_matches_mask: assert (any_hit == (mask != '0))
            else $error("match summary disagrees with mask");
    end
endmodule

// File: rtl/alu_exec_stage.sv
module alu_exec_stage #(
    parameter int XLEN = 64
) (
    input  logic [2:0]      op_i,
    input  logic [XLEN-1:0] a_i,
    input  logic [XLEN-1:0] b_i,
    input  logic            carry_i,
    input  logic            mode32_i,
    input  logic [3:0]      len_i,
    output logic [XLEN-1:0] result_o,
    output logic            result_ok_o,
    output logic [3:0]      cr0_o,
    output logic            cr0_ok_o,
    output logic            ov_o,
    output logic            ov32_o,
    output logic            ov_ok_o,
    output logic            ca_o,
    output logic            ca32_o,
    output logic            ca_ok_o
);
    import alu_pkg::*;

    localparam int HALF = XLEN / 2;

    logic [XLEN-1:0] opa, opb;
    logic [XLEN-1:0] add_sum, sext_y, cmp_mask;
    logic            add_c, add_c32, add_v, add_v32, cmp_any;

    // R6: upper halves read as zero in 32-bit mode
    assign opa = mode32_i ? {{HALF{1'b0}}, a_i[HALF-1:0]} : a_i;
    assign opb = mode32_i ? {{HALF{1'b0}}, b_i[HALF-1:0]} : b_i;

    alu_adder #(.XLEN(XLEN)) u_add (
        .a(opa), .b(opb), .cin(carry_i),
        .sum(add_sum), .cout(add_c), .cout_half(add_c32),
        .ovf(add_v), .ovf_half(add_v32)
    );

    alu_sext #(.XLEN(XLEN)) u_sext (
        .a(opa), .nbytes(len_i), .y(sext_y)
    );

    alu_bytecmp #(.XLEN(XLEN)) u_cmp (
        .key(opa[7:0]), .b(opb), .mask(cmp_mask), .any_hit(cmp_any)
    );

    always_comb begin
        result_o    = '0;
        result_ok_o = 1'b0;
        cr0_o       = '0;
        cr0_ok_o    = 1'b0;
        ov_o        = 1'b0;
        ov32_o      = 1'b0;
        ov_ok_o     = 1'b0;
        ca_o        = 1'b0;
        ca32_o      = 1'b0;
        ca_ok_o     = 1'b0;
        unique case (op_i)
            OP_ADD: begin
                result_o    = add_sum;
                result_ok_o = 1'b1;
                ca_o        = add_c;
                ca32_o      = add_c32;
                ov_o        = add_v;
                ov32_o      = add_v32;
                ov_ok_o     = 1'b1;
                ca_ok_o     = 1'b1;
            end
            OP_SEXT: begin
                result_o    = sext_y;
                result_ok_o = 1'b1;
            end
            OP_BCMP: begin
                result_o    = cmp_mask;
                result_ok_o = 1'b1;
                cr0_o       = {1'b0, cmp_any, 2'b00};
                cr0_ok_o    = 1'b1;
            end
            default: ;
        endcase
    end

    // R7 / R9: no valid result means every value output is quiet
    always_comb begin
        if (!result_ok_o) begin
            a_r9_idle_quiet: assert (result_o == '0 && cr0_o == '0 &&
                                     !ov_o && !ov32_o && !ca_o && !ca32_o)
                else $error("outputs active without a valid operation");
        end
    end

    // R8: at most one class of flag destination besides the result
    always_comb begin
        a_r8_flag_exclusive: assert (!(cr0_ok_o && (ov_ok_o || ca_ok_o)))
            else $error("condition and XER flags valid together");
        a_r8_ok_implies_result: assert (!(cr0_ok_o || ov_ok_o || ca_ok_o) || result_ok_o)
            else $error("flag valid without result valid");
    end

    // R10: condition field carries only the match bit
    always_comb begin
        a_r10_cr0_only_bit2: assert ((cr0_o & 4'b1011) == 4'b0000)
            else $error("unexpected condition field bit");
    end

    // R6: in 32-bit mode an add cannot carry out of the full width
    always_comb begin
        if (mode32_i && ca_ok_o) begin
            a_r6_no_top_carry: assert (!ca_o && result_o[XLEN-1:HALF+1] == '0)
                else $error("upper half active in 32-bit mode");
        end
    end
endmodule

// File: tb/alu_exec_stage_test.sv
module alu_exec_stage_test;
    localparam int XLEN = 64;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic [2:0]      op;
    logic [XLEN-1:0] a, b;
    logic            cin, m32;
    logic [3:0]      len;
    logic [XLEN-1:0] res;
    logic [3:0]      cr0;
    logic            res_ok, cr0_ok, ov, ov32, ov_ok, ca, ca32, ca_ok;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    alu_exec_stage #(.XLEN(XLEN)) uut (
        .op_i(op), .a_i(a), .b_i(b), .carry_i(cin), .mode32_i(m32), .len_i(len),
        .result_o(res), .result_ok_o(res_ok), .cr0_o(cr0), .cr0_ok_o(cr0_ok),
        .ov_o(ov), .ov32_o(ov32), .ov_ok_o(ov_ok),
        .ca_o(ca), .ca32_o(ca32), .ca_ok_o(ca_ok)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h (op=%0d a=%h b=%h c=%0b m32=%0b len=%0d)",
                     tag, act, exp, op, a, b, cin, m32, len);
        end
    endtask

    task automatic apply_and_check(input logic [2:0] o, input logic [63:0] ai,
                                   input logic [63:0] bi, input logic ci,
                                   input logic mi, input logic [3:0] li);
        logic [63:0] ea, eb, er;
        logic [64:0] w;
        logic [32:0] w32;
        logic [3:0]  ecr;
        logic        ec, ec32, ev, ev32, anyh;
        @(negedge clk);
        op = o; a = ai; b = bi; cin = ci; m32 = mi; len = li;
        #2;
        ea = mi ? {32'h0, ai[31:0]} : ai;
        eb = mi ? {32'h0, bi[31:0]} : bi;
        er = '0; ecr = '0; ec = 0; ec32 = 0; ev = 0; ev32 = 0;
        case (o)
            3'd1: begin
                w    = {1'b0, ea} + {1'b0, eb} + {64'h0, ci};
                w32  = {1'b0, ea[31:0]} + {1'b0, eb[31:0]} + {32'h0, ci};
                er   = w[63:0];
                ec   = w[64];
                ec32 = w32[32];
                ev   = (ec ^ er[63]) & ~(ea[63] ^ eb[63]);
                ev32 = (ec32 ^ er[31]) & ~(ea[31] ^ eb[31]);
            end
            3'd2: begin
                if (li == 4'd1)      er = {{56{ea[7]}},  ea[7:0]};
                else if (li == 4'd2) er = {{48{ea[15]}}, ea[15:0]};
                else if (li == 4'd4) er = {{32{ea[31]}}, ea[31:0]};
                else                 er = ea;
            end
            3'd3: begin
                anyh = 1'b0;
                for (int i = 0; i < 8; i++) begin
                    er[i] = (eb[8*i +: 8] == ea[7:0]);
                    anyh  = anyh | er[i];
                end
                ecr = {1'b0, anyh, 2'b00};
            end
            default: ;
        endcase
        check("R1/R4/R5/R6/R9 result", res, er);
        check("R1 ca", {63'h0, ca}, {63'h0, ec});
        check("R2 ca32", {63'h0, ca32}, {63'h0, ec32});
        check("R3 ov", {63'h0, ov}, {63'h0, ev});
        check("R3 ov32", {63'h0, ov32}, {63'h0, ev32});
        check("R5/R10 cr0", {60'h0, cr0}, {60'h0, ecr});
        check("R7 result_ok", {63'h0, res_ok}, {63'h0, (o >= 3'd1 && o <= 3'd3)});
        check("R8 ov_ok", {63'h0, ov_ok}, {63'h0, (o == 3'd1)});
        check("R8 ca_ok", {63'h0, ca_ok}, {63'h0, (o == 3'd1)});
        check("R8 cr0_ok", {63'h0, cr0_ok}, {63'h0, (o == 3'd3)});
    endtask

    initial begin
        logic [63:0] ra, rb;
        int unsigned seed;
        seed = 32'd12345;
        void'($urandom(seed));
        op = '0; a = '0; b = '0; cin = 0; m32 = 0; len = '0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // R9: idle state with op 0
        apply_and_check(3'd0, 64'h0, 64'h0, 0, 0, 4'd0);
        // R1 R2 R3: carries across both boundaries
        apply_and_check(3'd1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 1, 0, 4'd0);
        apply_and_check(3'd1, 64'h7FFF_FFFF_7FFF_FFFF, 64'h0000_0001_0000_0001, 0, 0, 4'd0);
        apply_and_check(3'd1, 64'h8000_0000_8000_0000, 64'h8000_0000_8000_0000, 0, 0, 4'd0);
        // R6: upper halves ignored in 32-bit mode
        apply_and_check(3'd1, 64'hDEAD_BEEF_FFFF_FFFF, 64'hCAFE_F00D_0000_0001, 0, 1, 4'd0);
        // R4: every length plus an unsupported one
        apply_and_check(3'd2, 64'h1234_5678_8765_4380, 64'h0, 0, 0, 4'd1);
        apply_and_check(3'd2, 64'h1234_5678_8765_8001, 64'h0, 0, 0, 4'd2);
        apply_and_check(3'd2, 64'h0000_0000_8765_4321, 64'h0, 0, 0, 4'd4);
        apply_and_check(3'd2, 64'h1234_5678_8765_4321, 64'h0, 0, 0, 4'd3);
        apply_and_check(3'd2, 64'hFFFF_FFFF_8000_0000, 64'h0, 0, 1, 4'd8);
        // R5: match in one byte, all bytes, none
        apply_and_check(3'd3, 64'h0000_0000_0000_00A5, 64'h00A5_0000_0000_0000, 0, 0, 4'd0);
        apply_and_check(3'd3, 64'h0000_0000_0000_0011, 64'h1111_1111_1111_1111, 0, 0, 4'd0);
        apply_and_check(3'd3, 64'h0000_0000_0000_0011, 64'h2222_2222_2222_2222, 0, 0, 4'd0);
        // R6 with compare: zeroed upper bytes match a zero key
        apply_and_check(3'd3, 64'hFF00_0000_0000_0000, 64'h5555_5555_0101_0101, 0, 1, 4'd0);
        // R7 R9: every unrecognised code
        for (int c = 4; c < 8; c++)
            apply_and_check(3'(c), 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1, 0, 4'd1);
        // random mix
        for (int n = 0; n < 400; n++) begin
            ra = {$urandom, $urandom};
            rb = {$urandom, $urandom};
            if (($urandom % 3) == 0) rb[8*($urandom % 8) +: 8] = ra[7:0];
            apply_and_check(3'($urandom % 8), ra, rb, 1'($urandom), 1'($urandom % 4 == 0),
                            4'($urandom % 6));
        end
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule